// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces memory addresses for a DSP-style datapath. It holds three banks of eight 14-bit registers: pointers, signed steps and buffer sizes. When a request selects a pointer and a step, the block returns that pointer's present value as the next access address. In the same clock edge it advances the pointer by the step. A size of zero gives plain linear stepping, which wraps only at the 16K-word limit of the address space. Any other size confines the pointer to a circular buffer of that many words.

The buffer's lowest address is fixed by the pointer and the size. The pointer's low bits are cleared, up to the smallest power of two that is not below the size. One request is accepted per clock. A build parameter lets an instance tag its addresses for program memory as well as data memory. An instance built without that option only ever targets data memory.

A small controller records what the last cycle did. It has three states. ST_IDLE means no result: reset lands here, and so does any cycle with no request. ST_ISSUE means an address is valid: it is entered on a request whose pointer and step share a bank. ST_FAULT means the last request was rejected: it is entered on a request whose pointer and step come from different banks. From every state the next state is picked only by the current cycle's request, following the same three rules.

Top module: `cbuf_addr_gen`

## Requirements
- R1: After reset every pointer, step and size register holds zero, and both addr_valid and sel_err are low (controller in ST_IDLE).
- R2: A request with matching banks produces addr_valid high in the next cycle, with addr_out equal to the selected pointer's value before the request.
- R3: With the selected size zero, the pointer becomes pointer plus step modulo 16384.
- R4: With a non-zero size L and a non-negative step, a sum at or above base+L is reduced by L.
- R5: With a non-zero size L and a negative step, a sum below base is increased by L.
- R6: base is the pointer with its low bits cleared up to the smallest power of two that is at least L, so non-power-of-two sizes still wrap inside an aligned block.
- R7: The bank is the top bit of each select, with pointers 0-3 and steps 0-3 forming one bank and 4-7 the other. A request whose pointer select and step select name different banks leaves all registers unchanged and gives sel_err high (not addr_valid) in the next cycle.
- R8: Requests on consecutive cycles each yield one address on consecutive cycles, in order, and a cycle without a request yields no output.
- R9: When a register write and a pointer update target the same pointer in one cycle, the written value is kept. The address output still shows the old value.
- R10: With PM_ENABLE=1, addr_pm repeats req_pm of the accepted request. With PM_ENABLE=0, addr_pm is always 0.
- R11: The step is a signed 14-bit two's-complement value, so step 16383 moves the pointer by -1.
- R12: The wr_kind encoding is 0 for pointer, 1 for step, 2 for size and 3 for no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Bank written: 0 pointer, 1 step, 2 size, 3 none |
| wr_sel | input | 3 | Register number within the bank |
| wr_data | input | 14 | Value written |
| req_valid | input | 1 | Address request |
| req_isel | input | 3 | Pointer register used |
| req_msel | input | 3 | Step register used |
| req_pm | input | 1 | Request targets program memory |
| addr_out | output | 14 | Address, registered |
| addr_valid | output | 1 | addr_out holds a new address |
| addr_pm | output | 1 | Address targets program memory |
| sel_err | output | 1 | Previous request rejected for bank mismatch |

## Verification
The assertions assume a known active value on req_valid and the two selects whenever reset is released. The modulo wrap is only correct when the step magnitude is smaller than the buffer size and the pointer already lies inside its buffer. The stimulus therefore writes each pointer inside its aligned block and keeps every step shorter than the size programmed beside it. Bank mismatches are driven on purpose, with known follow-up reads, so that the error path is exercised without breaking those limits.

// File: rtl/cbuf_agen_pkg.sv
package cbuf_agen_pkg;

    typedef enum logic [1:0] {
        WK_INDEX  = 2'b00,
        WK_MODIFY = 2'b01,
        WK_LENGTH = 2'b10,
        WK_NONE   = 2'b11
    } wr_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_FAULT = 2'b10
    } agen_state_e;

endpackage

// File: rtl/dag_regfile.sv
module dag_regfile #(
    parameter int AW   = 14,
    parameter int NREG = 8,
    parameter int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_kind,
    input  logic [SELW-1:0] wr_sel,
    input  logic [AW-1:0]   wr_data,
    input  logic            upd_en,
    input  logic [SELW-1:0] upd_sel,
    input  logic [AW-1:0]   upd_data,
    input  logic [SELW-1:0] rd_isel,
    input  logic [SELW-1:0] rd_msel,
    output logic [AW-1:0]   rd_index,
    output logic [AW-1:0]   rd_modify,
    output logic [AW-1:0]   rd_length
);
    import cbuf_agen_pkg::*;

    logic [AW-1:0] idx_q [NREG];
    logic [AW-1:0] mod_q [NREG];
    logic [AW-1:0] len_q [NREG];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (!rst_n) begin
                idx_q[k] <= '0;
                mod_q[k] <= '0;
                len_q[k] <= '0;
            end else begin
                // a software load outranks the post-update of the same pointer
                if (wr_en && wr_kind == WK_INDEX && wr_sel == SELW'(k))
                    idx_q[k] <= wr_data;
                else if (upd_en && upd_sel == SELW'(k))
                    idx_q[k] <= upd_data;
                if (wr_en && wr_kind == WK_MODIFY && wr_sel == SELW'(k))
                    mod_q[k] <= wr_data;
                if (wr_en && wr_kind == WK_LENGTH && wr_sel == SELW'(k))
                    len_q[k] <= wr_data;
            end
        end
    end

    assign rd_index  = idx_q[rd_isel];
    assign rd_modify = mod_q[rd_msel];
    assign rd_length = len_q[rd_isel];

endmodule

// File: rtl/dag_step_unit.sv
module dag_step_unit #(
    parameter int AW = 14
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);
    localparam int SW = AW + 2;

    logic [AW-1:0]        lm1;
    logic [AW-1:0]        span_mask;
    logic [AW-1:0]        base;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] lo_bound;
    logic signed [SW-1:0] hi_bound;
    logic signed [SW-1:0] len_s;
    logic signed [SW-1:0] fixed;

    always_comb begin
        lm1 = len - AW'(1);
        // smear the highest set bit downward: mask of the enclosing power of two
        for (int k = 0; k < AW; k++)
            span_mask[k] = |(lm1 >> k);
        base     = idx & ~span_mask;
        len_s    = $signed({2'b00, len});
        lo_bound = $signed({2'b00, base});
        hi_bound = lo_bound + len_s;
        sum      = $signed({2'b00, idx}) + $signed({{2{step[AW-1]}}, step});
        fixed    = sum;
        if (len != '0) begin
            if (!step[AW-1] && sum >= hi_bound)
                fixed = sum - len_s;
            else if (step[AW-1] && sum < lo_bound)
                fixed = sum + len_s;
        end
        nxt = fixed[AW-1:0];
    end

endmodule

// File: rtl/dag_ctrl_fsm.sv
module dag_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic cross_bank,
    output logic addr_valid,
    output logic sel_err
);
    import cbuf_agen_pkg::*;

    agen_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ISSUE, ST_FAULT: begin
                if (req_valid && cross_bank)
                    state_d = ST_FAULT;
                else if (req_valid)
                    state_d = ST_ISSUE;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        addr_valid = (state_q == ST_ISSUE);
        sel_err    = (state_q == ST_FAULT);
    end

endmodule

// File: rtl/cbuf_addr_gen.sv
module cbuf_addr_gen #(
    parameter int AW        = 14,
    parameter int NREG      = 8,
    parameter bit PM_ENABLE = 1'b1,
    localparam int SELW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_kind,
    input  logic [SELW-1:0] wr_sel,
    input  logic [AW-1:0]   wr_data,
    input  logic            req_valid,
    input  logic [SELW-1:0] req_isel,
    input  logic [SELW-1:0] req_msel,
    input  logic            req_pm,
    output logic [AW-1:0]   addr_out,
    output logic            addr_valid,
    output logic            addr_pm,
    output logic            sel_err
);
    logic          cross_bank;
    logic          accept;
    logic [AW-1:0] cur_index;
    logic [AW-1:0] cur_modify;
    logic [AW-1:0] cur_length;
    logic [AW-1:0] next_index;
    logic [AW-1:0] addr_q;

    // top select bit names the bank of four
    assign cross_bank = req_isel[SELW-1] ^ req_msel[SELW-1];
    assign accept     = req_valid && !cross_bank;

    dag_regfile #(.AW(AW), .NREG(NREG), .SELW(SELW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
        .upd_en(accept), .upd_sel(req_isel), .upd_data(next_index),
        .rd_isel(req_isel), .rd_msel(req_msel),
        .rd_index(cur_index), .rd_modify(cur_modify), .rd_length(cur_length)
    );

    dag_step_unit #(.AW(AW)) u_step (
        .idx(cur_index), .step(cur_modify), .len(cur_length), .nxt(next_index)
    );

    dag_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cross_bank(cross_bank),
        .addr_valid(addr_valid), .sel_err(sel_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (accept)
            addr_q <= cur_index;
    end
    assign addr_out = addr_q;

    generate
        if (PM_ENABLE) begin : g_pm
            logic pm_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pm_q <= 1'b0;
                else if (accept)
                    pm_q <= req_pm;
            end
            assign addr_pm = pm_q & addr_valid;
        end else begin : g_dm_only
            logic unused_pm;
            assign unused_pm = req_pm;
            assign addr_pm   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/cbuf_addr_gen_chk.sv
module cbuf_addr_gen_chk #(
    parameter int SELW      = 3,
    parameter bit PM_ENABLE = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [SELW-1:0] req_isel,
    input logic [SELW-1:0] req_msel,
    input logic            req_pm,
    input logic            addr_valid,
    input logic            addr_pm,
    input logic            sel_err
);
    logic same_bank;
    assign same_bank = (req_isel[SELW-1] == req_msel[SELW-1]);

    a_r2_valid_after_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && same_bank |=> addr_valid && !sel_err);

    a_r7_error_after_cross: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !same_bank |=> sel_err && !addr_valid);

    a_r8_quiet_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid && !sel_err);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_valid, sel_err}));

    a_r10_pm_tracks_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && same_bank |=> addr_pm == (PM_ENABLE && $past(req_pm)));

    a_r10_pm_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        addr_pm |-> addr_valid);

endmodule

bind cbuf_addr_gen cbuf_addr_gen_chk #(.SELW(SELW), .PM_ENABLE(PM_ENABLE)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_isel(req_isel),
    .req_msel(req_msel), .req_pm(req_pm), .addr_valid(addr_valid),
    .addr_pm(addr_pm), .sel_err(sel_err)
);

// File: tb/tb_cbuf_addr_gen.sv
`timescale 1ns/1ps
module tb_cbuf_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'b11;
    logic [2:0]  wr_sel = '0;
    logic [13:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_isel = '0;
    logic [2:0]  req_msel = '0;
    logic        req_pm = 1'b0;
    logic [13:0] addr_out, addr_out_dm;
    logic        addr_valid, addr_pm, sel_err;
    logic        addr_valid_dm, addr_pm_dm, sel_err_dm;

    always #2.5 clk = ~clk;

    cbuf_addr_gen #(.PM_ENABLE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_valid(req_valid), .req_isel(req_isel),
        .req_msel(req_msel), .req_pm(req_pm), .addr_out(addr_out),
        .addr_valid(addr_valid), .addr_pm(addr_pm), .sel_err(sel_err)
    );

    cbuf_addr_gen #(.PM_ENABLE(1'b0)) dut_dm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_valid(req_valid), .req_isel(req_isel),
        .req_msel(req_msel), .req_pm(req_pm), .addr_out(addr_out_dm),
        .addr_valid(addr_valid_dm), .addr_pm(addr_pm_dm), .sel_err(sel_err_dm)
    );

    typedef struct {
        bit          err;
        logic [13:0] addr;
        bit          pm;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          finished = 1'b0;
    logic [13:0] m_idx [8];
    logic [13:0] m_mod [8];
    logic [13:0] m_len [8];

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference step from the requirements (R3, R4, R5, R6, R11)
    function automatic logic [13:0] ref_next(logic [13:0] i, logic [13:0] m, logic [13:0] l);
        int span, base, s;
        s = int'(i) + ((m[13]) ? int'(m) - 16384 : int'(m));
        if (l == 0) return 14'(s);
        span = 1;
        while (span < int'(l)) span = span * 2;
        base = int'(i) - (int'(i) % span);
        if (!m[13] && s >= base + int'(l)) s = s - int'(l);
        else if (m[13] && s < base) s = s + int'(l);
        return 14'(s);
    endfunction

    task automatic put_reg(logic [1:0] kind, int sel, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = kind; wr_sel = 3'(sel); wr_data = 14'(data);
        req_valid = 1'b0;
        case (kind)
            2'b00: m_idx[sel] = 14'(data);
            2'b01: m_mod[sel] = 14'(data);
            2'b10: m_len[sel] = 14'(data);
            default: ;
        endcase
    endtask

    task automatic do_req(int isel, int msel, bit pm, string tag);
        exp_t e;
        @(negedge clk);
        wr_en = 1'b0;
        req_valid = 1'b1; req_isel = 3'(isel); req_msel = 3'(msel); req_pm = pm;
        e.tag = tag; e.pm = pm;
        if (isel[2] != msel[2]) begin
            e.err = 1'b1; e.addr = '0; e.pm = 1'b0;
        end else begin
            e.err = 1'b0; e.addr = m_idx[isel];
            m_idx[isel] = ref_next(m_idx[isel], m_mod[msel], m_len[isel]);
        end
        sb_q.push_back(e);
    endtask

    task automatic req_and_write(int sel, int data, string tag);
        exp_t e;
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 2'b00; wr_sel = 3'(sel); wr_data = 14'(data);
        req_valid = 1'b1; req_isel = 3'(sel); req_msel = 3'(sel); req_pm = 1'b0;
        e.err = 1'b0; e.addr = m_idx[sel]; e.pm = 1'b0; e.tag = tag;
        m_idx[sel] = 14'(data);
        sb_q.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 1'b0; req_valid = 1'b0;
        end
    endtask

    // monitor: compares every produced result against the queue head
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (addr_valid_dm)
                    check(addr_pm_dm == 1'b0, "R10 dm-only pm", int'(addr_pm_dm), 0);
                if (addr_valid || sel_err) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R8 unexpected output", int'(addr_out), -1);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check(sel_err == e.err, {e.tag, " err"}, int'(sel_err), int'(e.err));
                        if (!e.err) begin
                            check(addr_out == e.addr, {e.tag, " addr"}, int'(addr_out), int'(e.addr));
                            check(addr_pm == e.pm, {e.tag, " pm"}, int'(addr_pm), int'(e.pm));
                        end
                    end
                end
            end
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_idx[k] = '0; m_mod[k] = '0; m_len[k] = '0;
        end
        repeat (4) @(negedge clk);
        check(addr_valid == 1'b0, "R1 valid in reset", int'(addr_valid), 0);
        check(sel_err == 1'b0, "R1 err in reset", int'(sel_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(addr_valid == 1'b0 && sel_err == 1'b0, "R1 idle after reset",
              int'({addr_valid, sel_err}), 0);
        do_req(0, 0, 1'b0, "R1 zero pointer");
        do_req(0, 0, 1'b0, "R1 zero pointer again");
        idle(2);

        // R12: kind 3 writes nothing
        put_reg(2'b11, 0, 123);
        do_req(0, 0, 1'b0, "R12 kind 3 ignored");
        idle(1);

        // R3 linear stepping: 100,107,114 ; 16380 then 4
        put_reg(2'b00, 1, 100); put_reg(2'b01, 1, 7);
        put_reg(2'b00, 2, 16380); put_reg(2'b01, 2, 8);
        do_req(1, 1, 1'b0, "R3 linear");
        do_req(1, 1, 1'b0, "R8 back to back");
        do_req(1, 1, 1'b0, "R8 back to back");
        do_req(2, 2, 1'b0, "R3 linear");
        do_req(2, 2, 1'b0, "R3 wrap at 16K");
        idle(2);

        // R11 negative step: 5,4,3
        put_reg(2'b00, 0, 5); put_reg(2'b01, 0, 16383);
        do_req(0, 0, 1'b0, "R11 signed step");
        do_req(0, 0, 1'b0, "R11 signed step");
        do_req(0, 0, 1'b0, "R11 signed step");
        idle(1);

        // R4/R6: size 10 at 53 -> 53,57,51,55,49
        put_reg(2'b00, 4, 53); put_reg(2'b01, 4, 4); put_reg(2'b10, 4, 10);
        put_reg(2'b01, 7, 0);
        for (int k = 0; k < 5; k++) do_req(4, 4, 1'b1, "R4 R6 modulo up");
        // R5: size 8 at 259 step -3 -> 259,256,261,258
        put_reg(2'b00, 5, 259); put_reg(2'b01, 5, 16381); put_reg(2'b10, 5, 8);
        for (int k = 0; k < 4; k++) do_req(5, 5, 1'b0, "R5 modulo down");
        // power-of-two size 16 at 47 step 1 -> 47,32
        put_reg(2'b00, 6, 47); put_reg(2'b01, 6, 1); put_reg(2'b10, 6, 16);
        do_req(6, 6, 1'b1, "R4 pow2 size");
        do_req(6, 6, 1'b1, "R4 pow2 size");
        do_req(6, 7, 1'b1, "R6 read back");
        idle(2);

        // R7: cross-bank requests change nothing
        put_reg(2'b01, 3, 0);
        do_req(1, 5, 1'b0, "R7 cross bank");
        do_req(4, 2, 1'b1, "R7 cross bank");
        do_req(1, 3, 1'b0, "R7 pointer unchanged");
        do_req(4, 7, 1'b0, "R7 pointer unchanged");
        idle(2);

        // R9: write wins over the update of the same pointer
        req_and_write(1, 500, "R9 old value shown");
        do_req(1, 3, 1'b0, "R9 written value kept");
        idle(1);

        // R10 program-memory tag on alternating requests
        do_req(0, 3, 1'b1, "R10 pm tag");
        do_req(0, 3, 1'b0, "R10 dm tag");
        idle(4);

        check(sb_q.size() == 0, "R8 outstanding results", sb_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule